// File: doc/BRIEF.md
# Real-Time Clock Timebase and Update-Cycle Controller

This block turns a 32.768 kHz clock enable into the two time references that a real-time clock needs. The first is a once-per-second advance pulse for the neighbouring time-of-day counters, followed by an update-ended pulse. The second is a periodic tick whose rate is programmable. The block holds the control fields that govern both references: the divider-control and rate-select fields of control register A, and the stop, periodic-enable and update-ended-enable bits of control register B. It also drives the live update-in-progress status bit. That bit warns software, shortly before each advance, that the calendar is about to change.

The divider-control field selects one of three chain states. In the running state the chain counts. In the halted state the count is frozen. In the held-in-reset state the count is cleared. When the chain comes out of the held-in-reset state, the first advance is deliberately delayed by half a second. The periodic tick does not depend on the divider state. It is gated only by its enable bit and by its rate code.

Top module: `rtc_timebase`

## Requirements
- R1: After reset, the control register A readback is 0x26, with the update-in-progress bit in bit 7 and the write bits in bits 6:0. The stop, periodic-enable and update-ended-enable outputs are 0, and no pulse is asserted.
- R2: While running, `upd_o` pulses for one cycle every TICKS_PER_SEC cycles in which `tick_en` is high. The first pulse after reset comes TICKS_PER_SEC ticks after release. Cycles with `tick_en` low do not advance the chain.
- R3: `uf_o` pulses for one cycle, in the cycle after each `upd_o` pulse.
- R4: `uip_o` rises UIP_LEAD ticks before each advance. It falls in the same cycle that `upd_o` is asserted.
- R5: Bit 7 of control register A is read-only. A write replaces bits 6:0 only, and the readback bit 7 keeps showing the live update-in-progress state.
- R6: When bits 6:5 of register A are both 1 (divider reset), the second counter is held at zero. No `upd_o` or `uf_o` pulse occurs, and `uip_o` is 0.
- R7: A write that moves register A from the divider-reset state to a running code (bits 6:4 at most 2) gives the first `upd_o` TICKS_PER_SEC/2 ticks later. This applies only while stop is 0.
- R8: The chain advances only while stop is 0 and bits 6:4 of register A are at most 2. Any other code (for example 3) freezes the count. Setting stop clears `uip_o` at once.
- R9: A register B write with stop set forces `uie_o` to 0, whatever the update-ended-enable data bit is. A write with stop clear takes the data bit as given.
- R10: `pf_o` pulses once every period while periodic-enable is 1. The period is set by the rate code in register A bits 3:0: code 0 gives no pulses, codes 1 and 2 give 128 and 256 ticks, and codes 3 to 15 give 2^(code-1) ticks.
- R11: Clearing periodic-enable stops `pf_o`. A write that changes the rate code restarts the periodic count, so the next `pf_o` comes one full new period after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| ctla_wr | input | 1 | Write strobe for control register A |
| ctla_wdata | input | 8 | Write data for register A; bit 7 is ignored |
| ctlb_wr | input | 1 | Write strobe for the register B bits held here |
| ctlb_set | input | 1 | Stop (time-set) bit write data |
| ctlb_pie | input | 1 | Periodic-enable bit write data |
| ctlb_uie | input | 1 | Update-ended-enable bit write data |
| ctla_rd | output | 8 | Register A readback with the live update-in-progress bit in bit 7 |
| set_o | output | 1 | Stored stop bit |
| pie_o | output | 1 | Stored periodic-enable bit |
| uie_o | output | 1 | Stored update-ended-enable bit |
| upd_o | output | 1 | One-cycle advance pulse for the time-of-day counters |
| uf_o | output | 1 | One-cycle update-ended pulse |
| pf_o | output | 1 | One-cycle periodic pulse |
| uip_o | output | 1 | Live update-in-progress bit |

## Verification
The bench measures update and periodic intervals tick by tick. A design with an off-by-one divider terminal count would show intervals one tick long or short. A design that counted clock cycles instead of enabled ticks would halve the gap when `tick_en` toggles. The half-second release is timed exactly. A design that cleared the counter on release would take a full second, and one that forgot the release path would never leave reset. UIP is observed right before, at and after the advance, and also through a write to register A. A design that let the write overwrite bit 7, or kept UIP set through a stop request, would show a wrong readback. The periodic rate table covers every irregular code, a very long rate, rate changes in the middle of a period and the disable paths. A design with a wrong code map, or one that failed to restart the count, would give intervals other than the expected ones.

// File: rtl/rtc_tbase_pkg.sv
package rtc_tbase_pkg;

  // longest periodic interval is 2^RATE_MAX_EXP ticks
  localparam int RATE_MAX_EXP = 14;
  localparam int PER_W        = RATE_MAX_EXP + 1;

  // reset value of the writable bits of control register A
  localparam logic [6:0] CTLA_RST = 7'h26;

  // periodic rate code to period exponent; 0 means disabled
  function automatic logic [3:0] rate_exp(input logic [3:0] code);
    logic [3:0] e;
    case (code)
      4'd0:    e = 4'd0;
      4'd1:    e = 4'd7;
      4'd2:    e = 4'd8;
      default: e = code - 4'd1;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/rtc_tbase_regs.sv
module rtc_tbase_regs
  import rtc_tbase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_wr,
  input  logic [6:0] a_wdata,
  input  logic       b_wr,
  input  logic       b_set,
  input  logic       b_pie,
  input  logic       b_uie,
  output logic [6:0] a_q,
  output logic       set_q,
  output logic       pie_q,
  output logic       uie_q,
  output logic       run_q,
  output logic       run_nx,
  output logic       divrst_nx,
  output logic       release_nx,
  output logic       per_restart
);

  logic [6:0] a_nx;
  logic       set_nx, pie_nx, uie_nx;

  // next-state logic
  always_comb begin
    a_nx   = a_q;
    set_nx = set_q;
    pie_nx = pie_q;
    uie_nx = uie_q;
    if (a_wr) begin
      a_nx = a_wdata;
    end
    if (b_wr) begin
      set_nx = b_set;
      pie_nx = b_pie;
      uie_nx = b_uie & ~b_set;   // stopping the clock masks update-ended enable
    end
  end

  assign run_q      = ~set_q  & (a_q[6:4]  <= 3'd2);
  assign run_nx     = ~set_nx & (a_nx[6:4] <= 3'd2);
  assign divrst_nx  = (a_nx[6:5] == 2'b11);
  assign release_nx = a_wr & (a_q[6:5] == 2'b11) & (a_wdata[6:4] <= 3'd2) & ~set_q;
  assign per_restart = (a_wr & (a_wdata[3:0] != a_q[3:0])) |
                       (b_wr & (b_pie != pie_q));

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= CTLA_RST;
      set_q <= 1'b0;
      pie_q <= 1'b0;
      uie_q <= 1'b0;
    end else begin
      a_q   <= a_nx;
      set_q <= set_nx;
      pie_q <= pie_nx;
      uie_q <= uie_nx;
    end
  end

endmodule

// File: rtl/rtc_tbase_chain.sv
module rtc_tbase_chain #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run_q,
  input  logic run_nx,
  input  logic divrst_nx,
  input  logic release_nx,
  output logic upd_q,
  output logic uf_q,
  output logic uip_q
);

  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] CNT_UIP  = CW'(TICKS_PER_SEC - UIP_LEAD);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          upd_nx, uf_nx, uip_nx, wrap;

  assign wrap = run_q & tick_en & (cnt_q == CNT_LAST);

  // next-state logic
  always_comb begin
    cnt_nx = cnt_q;
    if (divrst_nx) begin
      cnt_nx = '0;
    end else if (release_nx) begin
      cnt_nx = CNT_HALF;
    end else if (run_q && tick_en) begin
      cnt_nx = wrap ? '0 : cnt_q + CW'(1);
    end
    upd_nx = wrap & run_nx & ~divrst_nx & ~release_nx;
    uf_nx  = upd_q & ~divrst_nx;
    uip_nx = run_nx & (cnt_nx >= CNT_UIP);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
      uf_q  <= 1'b0;
      uip_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      upd_q <= upd_nx;
      uf_q  <= uf_nx;
      uip_q <= uip_nx;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);                                         // R2
  AST_UIP_BEFORE_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> $past(uip_q));                                    // R4
  AST_UIP_FALLS_AT_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> !uip_q);                                          // R4
  AST_UF_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    uf_q |-> $past(upd_q));                                     // R3

endmodule

// File: rtl/rtc_tbase_periodic.sv
module rtc_tbase_periodic
  import rtc_tbase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       pie_q,
  input  logic [3:0] rate_q,
  input  logic       restart,
  output logic       pf_q
);

  logic [PER_W-1:0] cnt_q, cnt_nx, limit;
  logic [3:0]       expo;
  logic             active, pf_nx;

  assign expo   = rate_exp(rate_q);
  assign active = pie_q & (expo != 4'd0);
  assign limit  = (PER_W'(1) << expo) - PER_W'(1);

  // next-state logic
  always_comb begin
    cnt_nx = cnt_q;
    pf_nx  = 1'b0;
    if (restart || !active) begin
      cnt_nx = '0;
    end else if (tick_en) begin
      if (cnt_q >= limit) begin
        cnt_nx = '0;
        pf_nx  = 1'b1;
      end else begin
        cnt_nx = cnt_q + PER_W'(1);
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pf_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      pf_q  <= pf_nx;
    end
  end

  AST_PF_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_q |-> $past(pie_q && (rate_q != 4'd0)));                 // R10
  AST_PF_NOT_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> !pf_q);                                  // R11

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       ctla_wr,
  input  logic [7:0] ctla_wdata,
  input  logic       ctlb_wr,
  input  logic       ctlb_set,
  input  logic       ctlb_pie,
  input  logic       ctlb_uie,
  output logic [7:0] ctla_rd,
  output logic       set_o,
  output logic       pie_o,
  output logic       uie_o,
  output logic       upd_o,
  output logic       uf_o,
  output logic       pf_o,
  output logic       uip_o
);

  logic [6:0] a_q;
  logic       run_q, run_nx, divrst_nx, release_nx, per_restart;
  logic       wr_b7_unused;

  assign wr_b7_unused = ctla_wdata[7];   // status bit is not writable

  rtc_tbase_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .a_wr        (ctla_wr),
    .a_wdata     (ctla_wdata[6:0]),
    .b_wr        (ctlb_wr),
    .b_set       (ctlb_set),
    .b_pie       (ctlb_pie),
    .b_uie       (ctlb_uie),
    .a_q         (a_q),
    .set_q       (set_o),
    .pie_q       (pie_o),
    .uie_q       (uie_o),
    .run_q       (run_q),
    .run_nx      (run_nx),
    .divrst_nx   (divrst_nx),
    .release_nx  (release_nx),
    .per_restart (per_restart)
  );

  rtc_tbase_chain #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .UIP_LEAD      (UIP_LEAD)
  ) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .run_q      (run_q),
    .run_nx     (run_nx),
    .divrst_nx  (divrst_nx),
    .release_nx (release_nx),
    .upd_q      (upd_o),
    .uf_q       (uf_o),
    .uip_q      (uip_o)
  );

  rtc_tbase_periodic u_periodic (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .pie_q   (pie_o),
    .rate_q  (a_q[3:0]),
    .restart (per_restart),
    .pf_q    (pf_o)
  );

  assign ctla_rd = {uip_o, a_q};

  AST_DIVRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (a_q[6:5] == 2'b11) |-> (!upd_o && !uf_o && !uip_o));       // R6
  AST_STOP_DROPS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |-> !uip_o);                                          // R8
  AST_NO_UPD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (set_o && $past(set_o)) |-> !upd_o);                        // R8

endmodule

// File: tb/test_rtc_timebase.sv
module test_rtc_timebase;

  localparam int CLK_PERIOD = 10;
  localparam int SEC        = 256;
  localparam int LEAD       = 8;
  localparam int NVEC       = 7;
  // {rate code, expected period in ticks}
  localparam int VEC [NVEC][2] = '{
    '{3, 4}, '{1, 128}, '{4, 8}, '{2, 256}, '{15, 16384}, '{9, 256}, '{6, 32}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic       ctla_wr;
  logic [7:0] ctla_wdata;
  logic       ctlb_wr, ctlb_set, ctlb_pie, ctlb_uie;
  logic [7:0] ctla_rd;
  logic       set_o, pie_o, uie_o, upd_o, uf_o, pf_o, uip_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rtc_timebase #(
    .TICKS_PER_SEC (SEC),
    .UIP_LEAD      (LEAD)
  ) i_rtc_timebase (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .ctla_wr    (ctla_wr),
    .ctla_wdata (ctla_wdata),
    .ctlb_wr    (ctlb_wr),
    .ctlb_set   (ctlb_set),
    .ctlb_pie   (ctlb_pie),
    .ctlb_uie   (ctlb_uie),
    .ctla_rd    (ctla_rd),
    .set_o      (set_o),
    .pie_o      (pie_o),
    .uie_o      (uie_o),
    .upd_o      (upd_o),
    .uf_o       (uf_o),
    .pf_o       (pf_o),
    .uip_o      (uip_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_a(input logic [7:0] v);
    ctla_wr = 1'b1; ctla_wdata = v;
    @(negedge clk);
    ctla_wr = 1'b0;
  endtask

  task automatic wr_b(input logic s, input logic p, input logic u);
    ctlb_wr = 1'b1; ctlb_set = s; ctlb_pie = p; ctlb_uie = u;
    @(negedge clk);
    ctlb_wr = 1'b0;
  endtask

  task automatic to_upd(output int n, input int lim);
    n = 0;
    do begin @(negedge clk); n++; end while (!upd_o && n < lim);
  endtask

  task automatic to_pf(output int n, input int lim);
    n = 0;
    do begin @(negedge clk); n++; end while (!pf_o && n < lim);
  endtask

  task automatic wait_uip();
    for (int i = 0; i < 2 * SEC && !uip_o; i++) @(negedge clk);
  endtask

  // counts upd/uf/uip/pf events over a window
  task automatic quiet(input int cyc, output int nu, output int nf, output int ni,
                       output int np);
    nu = 0; nf = 0; ni = 0; np = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      nu += int'(upd_o); nf += int'(uf_o); ni += int'(uip_o); np += int'(pf_o);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, first_uip, nu, nf, ni, np;
    rst_n = 1'b0; tick_en = 1'b1; ctla_wr = 1'b0; ctla_wdata = '0;
    ctlb_wr = 1'b0; ctlb_set = 1'b0; ctlb_pie = 1'b0; ctlb_uie = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(ctla_rd == 8'h26, "R1 ctla", ctla_rd, 8'h26);
    chk({set_o, pie_o, uie_o, upd_o, uf_o, pf_o, uip_o} == 7'b0, "R1 flags",
        {set_o, pie_o, uie_o, upd_o, uf_o, pf_o, uip_o}, 0);

    // R2 / R4 first second after reset
    n = 0; first_uip = -1;
    do begin
      @(negedge clk); n++;
      if (uip_o && first_uip < 0) first_uip = n;
    end while (!upd_o && n < 2 * SEC);
    chk(n == SEC, "R2 first update", n, SEC);
    chk(first_uip == SEC - LEAD, "R4 uip lead", first_uip, SEC - LEAD);
    chk(!uip_o, "R4 uip falls at update", uip_o, 0);
    to_upd(n, 2 * SEC);
    chk(n == SEC, "R2 update gap", n, SEC);
    @(negedge clk);
    chk(uf_o && !upd_o, "R3 update ended", uf_o, 1);

    // R5 status bit is read-only
    wait_uip();
    wr_a(8'h26);
    chk(ctla_rd == 8'hA6, "R5 uip kept across write", ctla_rd, 8'hA6);
    to_upd(n, 2 * SEC);
    wr_a(8'hA6);
    chk(ctla_rd == 8'h26, "R5 bit7 not writable", ctla_rd, 8'h26);

    // R2 only enabled ticks count
    to_upd(n, 2 * SEC);
    tick_en = 1'b0; n = 0;
    do begin
      @(negedge clk); n++;
      if (!upd_o) tick_en = ~tick_en;
    end while (!upd_o && n < 4 * SEC);
    tick_en = 1'b1;
    chk(n == 2 * SEC, "R2 gap with half-rate ticks", n, 2 * SEC);
    tick_en = 1'b0;
    quiet(3 * SEC, nu, nf, ni, np);
    tick_en = 1'b1;
    chk(nu == 0, "R2 no update without ticks", nu, 0);

    // R6 divider reset, R7 release
    wr_a(8'h66);
    quiet(3 * SEC, nu, nf, ni, np);
    chk(nu + nf + ni == 0, "R6 divider reset quiet", nu + nf + ni, 0);
    chk(ctla_rd == 8'h66, "R6 ctla readback", ctla_rd, 8'h66);
    wr_a(8'h26);
    to_upd(n, 2 * SEC);
    chk(n == SEC / 2, "R7 half-second release", n, SEC / 2);

    // R8 halting code
    wr_a(8'h36);
    quiet(3 * SEC, nu, nf, ni, np);
    chk(nu + ni == 0, "R8 halted code", nu + ni, 0);
    wr_a(8'h26);

    // R8 / R9 stop bit
    wait_uip();
    wr_b(1'b1, 1'b0, 1'b1);
    chk(!uip_o, "R8 stop clears uip", uip_o, 0);
    chk(!uie_o && set_o, "R9 stop masks uie", uie_o, 0);
    quiet(3 * SEC, nu, nf, ni, np);
    chk(nu == 0, "R8 no update while stopped", nu, 0);
    wr_b(1'b0, 1'b0, 1'b1);
    chk(uie_o, "R9 uie taken when running", uie_o, 1);

    // R10 / R11 periodic rate table
    wr_b(1'b0, 1'b1, 1'b0);
    for (int v = 0; v < NVEC; v++) begin
      wr_a(8'h20 | 8'(VEC[v][0]));
      to_pf(n, 20000);
      chk(n == VEC[v][1], "R11 restart on rate change", n, VEC[v][1]);
      to_pf(n, 20000);
      chk(n == VEC[v][1], "R10 periodic interval", n, VEC[v][1]);
    end

    // R10 rate code 0
    wr_a(8'h20);
    quiet(300, nu, nf, ni, np);
    chk(np == 0, "R10 code 0 silent", np, 0);

    // R11 enable clear and mid-period change
    wr_a(8'h23);
    to_pf(n, 100);
    chk(n == 4, "R10 code 3 after code 0", n, 4);
    wr_b(1'b0, 1'b0, 1'b0);
    quiet(100, nu, nf, ni, np);
    chk(np == 0, "R11 enable clear stops pf", np, 0);
    wr_b(1'b0, 1'b1, 1'b0);
    to_pf(n, 100);
    repeat (2) @(negedge clk);
    wr_a(8'h24);
    to_pf(n, 100);
    chk(n == 8, "R11 mid-period restart", n, 8);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule